// File: doc/BRIEF.md
# Global Refresh Sequencer for a Dynamic-Cell Cache

This block keeps a cache array built from dynamic cells fast to access. Such cells hold their fast-access charge only for a limited time after each write. A programmable period timer fires once per retention interval and starts a refresh sweep over the whole array. The sweep does not use a dedicated refresh port. It takes over one existing read port and one existing write port. Each line is read one narrow slice per cycle, and every slice is written back to the same address on the following cycle. The read of the next slice overlaps that write-back.

While the sweep runs, a stall output tells the load/store scheduler to hold off normal accesses. A steal output marks the exact cycles in which the ports are in use. When slice 0 of a line is read and written back, a strobe is raised so that the tag of that line can be refreshed alongside its data.

A sweep always runs to its end. If the timer fires while a sweep is running, the start is remembered and the next sweep begins after the current one completes. If a nonzero period is programmed that is shorter than one full sweep, a sticky error flag is set.

Top module: `dyncache_refresh_seq`

## Requirements
- R1: While reset is held, stall, steal, both port enables, both tag strobes and the error flag are all 0.
- R2: With a programmed period P that is nonzero and large enough, the timer fires every P cycles. The first firing comes P cycles after reset release or after a period load, and stall rises on the cycle after each firing.
- R3: Stall rises one cycle before the first steal cycle and falls one cycle after the last write-back. A sweep holds stall for LINES*SLICES+3 consecutive cycles.
- R4: A sweep issues exactly LINES*SLICES reads on consecutive cycles, in this order: slice 0 up to SLICES-1 within a line, lines in ascending order, starting at line 0 slice 0.
- R5: Each read is followed on the next cycle by a write-back to the same line and slice. The write-back data is the read data returned by the array, so the array contents are unchanged by a sweep.
- R6: The read and write enables are asserted only while steal is high. Steal is high only during stall.
- R7: The tag read strobe accompanies every read of slice 0, and the tag write strobe accompanies every write-back of slice 0.
- R8: A sweep is never cut short. A timer firing during a sweep is held, and a new sweep starts on the second cycle after the current stall ends. Several firings during one sweep start only one sweep.
- R9: Loading a nonzero period below LINES*SLICES+3 sets the error flag, which stays set until reset. A period of 0 stops the timer and does not set the flag.
- R10: Loading a period restarts the timer count from zero, so the next firing comes P cycles after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_we_i | input | 1 | Load strobe for the retention period |
| period_i | input | PERIOD_W | Retention period in cycles (0 stops the timer) |
| rd_data_i | input | SLICE_W | Slice data returned by the array, one cycle after a read |
| stall_o | output | 1 | Hold off normal loads and stores |
| steal_o | output | 1 | One read and one write port are in refresh use |
| rd_en_o | output | 1 | Refresh read strobe |
| rd_line_o | output | LINE_W | Line address of the refresh read |
| rd_slice_o | output | SLICE_AW | Slice address of the refresh read |
| tag_rd_o | output | 1 | Tag read strobe for the line being read |
| wr_en_o | output | 1 | Refresh write-back strobe |
| wr_line_o | output | LINE_W | Line address of the write-back |
| wr_slice_o | output | SLICE_AW | Slice address of the write-back |
| wr_data_o | output | SLICE_W | Write-back data |
| tag_wr_o | output | 1 | Tag write strobe for the line written back |
| cfg_err_o | output | 1 | Sticky error: period shorter than a sweep |

## Verification
The bench builds the block with 4 lines of 4 slices, 8-bit slices, an 8-bit period field and a reset period of 30. These values make a sweep last only 19 cycles, so a few hundred cycles cover many complete sweeps, several period reloads and the period boundary at exactly 19. A period of 10 makes the timer fire during every sweep, which exercises held starts and back-to-back sweeps. A period of 0 then shows the timer stopping.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SWEEP = 3'd2,
    ST_DRAIN = 3'd3,
    ST_TAIL  = 3'd4
  } rfsh_state_e;

endpackage

// File: rtl/rfsh_period_timer.sv
module rfsh_period_timer #(
  parameter int PERIOD_W   = 16,
  parameter int PERIOD_RST = 25800,
  parameter int SWEEP_LEN  = 2051
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [PERIOD_W-1:0] val_i,
  output logic                tick_o,
  output logic                cfg_err_o
);

  localparam logic [PERIOD_W-1:0] RST_VAL = PERIOD_W'(PERIOD_RST);
  localparam logic [PERIOD_W-1:0] MIN_VAL = PERIOD_W'(SWEEP_LEN);

  logic [PERIOD_W-1:0] period_q, period_d;
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                err_q, err_d;
  logic                running;
  logic                tick;

  always_comb begin
    running  = (period_q != '0);
    tick     = running && (cnt_q == (period_q - 1'b1)) && !load_i;
    period_d = period_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    if (load_i) begin
      period_d = val_i;
      cnt_d    = '0;
      if ((val_i != '0) && (val_i < MIN_VAL)) begin
        err_d = 1'b1;
      end
    end else if (running) begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= RST_VAL;
      cnt_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      period_q <= period_d;
      cnt_q    <= cnt_d;
      err_q    <= err_d;
    end
  end

  assign tick_o    = tick;
  assign cfg_err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R9

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/rfsh_addr_gen.sv
module rfsh_addr_gen #(
  parameter int LINES  = 256,
  parameter int SLICES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      adv_i,
  output logic [$clog2(LINES)-1:0]  line_o,
  output logic [$clog2(SLICES)-1:0] slice_o,
  output logic                      last_o
);

  localparam int LINE_W   = $clog2(LINES);
  localparam int SLICE_AW = $clog2(SLICES);
  localparam logic [LINE_W-1:0]   LINE_MAX  = LINE_W'(LINES - 1);
  localparam logic [SLICE_AW-1:0] SLICE_MAX = SLICE_AW'(SLICES - 1);

  logic [LINE_W-1:0]   line_q, line_d;
  logic [SLICE_AW-1:0] slice_q, slice_d;
  logic                slice_wrap;

  always_comb begin
    slice_wrap = (slice_q == SLICE_MAX);
    line_d     = line_q;
    slice_d    = slice_q;
    if (clr_i) begin
      line_d  = '0;
      slice_d = '0;
    end else if (adv_i) begin
      slice_d = slice_wrap ? '0 : slice_q + 1'b1;
      if (slice_wrap) begin
        line_d = (line_q == LINE_MAX) ? '0 : line_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      slice_q <= '0;
    end else if (clr_i || adv_i) begin
      line_q  <= line_d;
      slice_q <= slice_d;
    end
  end

  assign line_o  = line_q;
  assign slice_o = slice_q;
  assign last_o  = slice_wrap && (line_q == LINE_MAX);

  AST_SLICE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && !slice_wrap) |=> (slice_q == $past(slice_q) + 1'b1)); // R4

endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic last_i,
  output logic stall_o,
  output logic steal_o,
  output logic rd_en_o,
  output logic wr_en_o,
  output logic clr_o,
  output logic adv_o
);

  rfsh_state_e state_q, state_d;
  logic        pend_q, pend_d;
  logic        wr_en_q;
  logic        start_req;

  always_comb begin
    start_req = tick_i || pend_q;
    state_d   = state_q;
    pend_d    = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (start_req) state_d = ST_LEAD;
      end
      ST_LEAD: begin
        if (tick_i) pend_d = 1'b1;
        state_d = ST_SWEEP;
      end
      ST_SWEEP: begin
        if (tick_i) pend_d = 1'b1;
        if (last_i) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (tick_i) pend_d = 1'b1;
        state_d = ST_TAIL;
      end
      ST_TAIL: begin
        if (tick_i) pend_d = 1'b1;
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      wr_en_q <= rd_en_o;
    end
  end

  assign stall_o = (state_q != ST_IDLE);
  assign steal_o = (state_q == ST_SWEEP) || (state_q == ST_DRAIN);
  assign rd_en_o = (state_q == ST_SWEEP);
  assign wr_en_o = wr_en_q;
  assign clr_o   = (state_q == ST_LEAD);
  assign adv_o   = (state_q == ST_SWEEP);

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SWEEP && !last_i) |=> (state_q == ST_SWEEP)); // R8

  AST_HELD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL && (pend_q || tick_i)) |=> ##1 (state_q == ST_LEAD)); // R8

endmodule

// File: rtl/dyncache_refresh_seq.sv
module dyncache_refresh_seq #(
  parameter int LINES      = 256,
  parameter int SLICES     = 8,
  parameter int SLICE_W    = 64,
  parameter int PERIOD_W   = 16,
  parameter int PERIOD_RST = 25800,
  parameter int LINE_W     = $clog2(LINES),
  parameter int SLICE_AW   = $clog2(SLICES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                period_we_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [SLICE_W-1:0]  rd_data_i,
  output logic                stall_o,
  output logic                steal_o,
  output logic                rd_en_o,
  output logic [LINE_W-1:0]   rd_line_o,
  output logic [SLICE_AW-1:0] rd_slice_o,
  output logic                tag_rd_o,
  output logic                wr_en_o,
  output logic [LINE_W-1:0]   wr_line_o,
  output logic [SLICE_AW-1:0] wr_slice_o,
  output logic [SLICE_W-1:0]  wr_data_o,
  output logic                tag_wr_o,
  output logic                cfg_err_o
);

  localparam int SWEEP_LEN = LINES * SLICES + 3;

  logic                tick;
  logic                last;
  logic                clr;
  logic                adv;
  logic                rd_en;
  logic                wr_en;
  logic [LINE_W-1:0]   rd_line;
  logic [SLICE_AW-1:0] rd_slice;
  logic [LINE_W-1:0]   wb_line_q;
  logic [SLICE_AW-1:0] wb_slice_q;

  rfsh_period_timer #(
    .PERIOD_W   (PERIOD_W),
    .PERIOD_RST (PERIOD_RST),
    .SWEEP_LEN  (SWEEP_LEN)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (period_we_i),
    .val_i     (period_i),
    .tick_o    (tick),
    .cfg_err_o (cfg_err_o)
  );

  rfsh_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .last_i  (last),
    .stall_o (stall_o),
    .steal_o (steal_o),
    .rd_en_o (rd_en),
    .wr_en_o (wr_en),
    .clr_o   (clr),
    .adv_o   (adv)
  );

  rfsh_addr_gen #(
    .LINES  (LINES),
    .SLICES (SLICES)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .adv_i   (adv),
    .line_o  (rd_line),
    .slice_o (rd_slice),
    .last_o  (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_line_q  <= '0;
      wb_slice_q <= '0;
    end else if (rd_en) begin
      wb_line_q  <= rd_line;
      wb_slice_q <= rd_slice;
    end
  end

  assign rd_en_o    = rd_en;
  assign rd_line_o  = rd_line;
  assign rd_slice_o = rd_slice;
  assign tag_rd_o   = rd_en && (rd_slice == '0);
  assign wr_en_o    = wr_en;
  assign wr_line_o  = wb_line_q;
  assign wr_slice_o = wb_slice_q;
  assign wr_data_o  = rd_data_i;
  assign tag_wr_o   = wr_en && (wb_slice_q == '0);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(stall_o || steal_o || rd_en_o || wr_en_o || cfg_err_o)); // R1

  AST_PORTS_IN_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o || wr_en_o) |-> steal_o); // R6

  AST_STEAL_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    steal_o |-> stall_o); // R6

  AST_STALL_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steal_o) |-> $past(stall_o)); // R3

  AST_STALL_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steal_o) |-> stall_o); // R3

  AST_WB_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> (wr_en_o && wr_line_o == $past(rd_line_o)
                 && wr_slice_o == $past(rd_slice_o))); // R5

  AST_TAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    tag_rd_o |=> tag_wr_o); // R7

endmodule

// File: tb/tb_dyncache_refresh_seq.sv
`timescale 1ns/1ps
module tb_dyncache_refresh_seq;

  localparam int LINES  = 4;
  localparam int SLICES = 4;
  localparam int SW     = 8;
  localparam int PW     = 8;
  localparam int PRST   = 30;
  localparam int N      = LINES * SLICES;
  localparam int LW     = $clog2(LINES);
  localparam int SAW    = $clog2(SLICES);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          period_we;
  logic [PW-1:0] period_v;
  logic [SW-1:0] rd_data;
  logic          stall, steal, rd_en, tag_rd, wr_en, tag_wr, cfg_err;
  logic [LW-1:0]  rd_line, wr_line;
  logic [SAW-1:0] rd_slice, wr_slice;
  logic [SW-1:0]  wr_data;

  logic [SW-1:0] mem  [N];
  logic [SW-1:0] gold [N];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int m_per, m_cnt, m_pos;
  bit m_pend, m_err;

  always #2.5 clk = ~clk;

  dyncache_refresh_seq #(
    .LINES(LINES), .SLICES(SLICES), .SLICE_W(SW),
    .PERIOD_W(PW), .PERIOD_RST(PRST)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .period_we_i(period_we), .period_i(period_v), .rd_data_i(rd_data),
    .stall_o(stall), .steal_o(steal),
    .rd_en_o(rd_en), .rd_line_o(rd_line), .rd_slice_o(rd_slice), .tag_rd_o(tag_rd),
    .wr_en_o(wr_en), .wr_line_o(wr_line), .wr_slice_o(wr_slice), .wr_data_o(wr_data),
    .tag_wr_o(tag_wr), .cfg_err_o(cfg_err)
  );

  // behavioural array: one-cycle read latency, write at the edge
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[int'(rd_line) * SLICES + int'(rd_slice)];
    if (wr_en) mem[int'(wr_line) * SLICES + int'(wr_slice)] <= wr_data;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_stall, e_steal, e_rd, e_wr;
    int ri, wi;
    e_stall = (m_pos >= 0);
    e_steal = (m_pos >= 1) && (m_pos <= N + 1);
    e_rd    = (m_pos >= 1) && (m_pos <= N);
    e_wr    = (m_pos >= 2) && (m_pos <= N + 1);
    ri = m_pos - 1;
    wi = m_pos - 2;
    chk(stall == e_stall, "R2/R3 stall", stall, e_stall);
    chk(steal == e_steal, "R3/R6 steal", steal, e_steal);
    chk(rd_en == e_rd, "R4 rd_en", rd_en, e_rd);
    chk(wr_en == e_wr, "R5 wr_en", wr_en, e_wr);
    chk(cfg_err == m_err, "R9 cfg_err", cfg_err, m_err);
    if (e_rd) begin
      chk(int'(rd_line) * SLICES + int'(rd_slice) == ri, "R4 rd addr",
          int'(rd_line) * SLICES + int'(rd_slice), ri);
      chk(tag_rd == (ri % SLICES == 0), "R7 tag_rd", tag_rd, ri % SLICES == 0);
    end else begin
      chk(tag_rd == 1'b0, "R7 tag_rd idle", tag_rd, 0);
    end
    if (e_wr) begin
      chk(int'(wr_line) * SLICES + int'(wr_slice) == wi, "R5 wr addr",
          int'(wr_line) * SLICES + int'(wr_slice), wi);
      chk(wr_data == gold[wi], "R5 wr data", wr_data, gold[wi]);
      chk(tag_wr == (wi % SLICES == 0), "R7 tag_wr", tag_wr, wi % SLICES == 0);
    end else begin
      chk(tag_wr == 1'b0, "R7 tag_wr idle", tag_wr, 0);
    end
  endtask

  task automatic model_step(input bit we, input int v);
    bit tick;
    tick = (m_per != 0) && (m_cnt == m_per - 1) && !we;
    if (m_pos < 0) begin
      if (tick || m_pend) begin
        m_pos  = 0;
        m_pend = 0;
      end
    end else begin
      if (tick) m_pend = 1;   // R8 held start
      m_pos++;
      if (m_pos > N + 2) m_pos = -1;
    end
    if (we) m_cnt = 0;        // R10
    else if (m_per != 0) m_cnt = tick ? 0 : m_cnt + 1;
    if (we) begin
      m_per = v;
      if (v != 0 && v < N + 3) m_err = 1;
    end
  endtask

  task automatic step(input bit we, input int v);
    period_we = we;
    period_v  = PW'(v);
    compare();
    model_step(we, v);
    @(negedge clk);
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) step(1'b0, 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    period_we = 1'b0;
    period_v  = '0;
    rd_data   = '0;
    for (int i = 0; i < N; i++) begin
      gold[i] = SW'(i * 37 + 5);
      mem[i]  = SW'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!stall && !steal, "R1 stall/steal", {stall, steal}, 0);
    chk(!rd_en && !wr_en, "R1 enables", {rd_en, wr_en}, 0);
    chk(!tag_rd && !tag_wr, "R1 tags", {tag_rd, tag_wr}, 0);
    chk(!cfg_err, "R1 cfg_err", cfg_err, 0);
    rst_n = 1'b1;
    m_per = PRST; m_cnt = 0; m_pos = -1; m_pend = 0; m_err = 0;

    run(100);              // R2 reset period, several sweeps
    step(1'b1, 25);        // R10 reload
    run(80);
    step(1'b1, N + 3);     // R9 boundary: no error
    run(60);
    step(1'b1, 10);        // R9 error, R8 held starts
    run(100);
    step(1'b1, 0);         // R9 zero stops timer
    run(60);
    chk(stall == 1'b0, "R9 timer stopped", stall, 0);

    for (int i = 0; i < N; i++)
      chk(mem[i] == gold[i], "R5 array intact", mem[i], gold[i]);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule